// File: doc/BRIEF.md
# Serial Converter Acquisition Sequencer

This block runs the host side of a serial link to a 16-bit successive-approximation converter. A request on a parallel port selects the input range, the conversion clock source, the operation, and three auxiliary output bits. From these the sequencer builds the 8-bit command word and shifts it out on a four-wire serial bus. Depending on the operation, it then either keeps the serial clock running and captures the result bits as they arrive, or parks the clock and waits on the converter's strobe line. When the operation ends, the sequencer pulses `done` and presents the 16-bit result along with a flag that tells the consumer whether to read the result as signed.

The serial clock comes from a divider on the system clock, so the converter's clock limit is met through a parameter. Calibration and power-down use the same request port. A calibration ends on the strobe edge that belongs to the chosen clock source. Any wait on the strobe is bounded, and if it runs out the operation ends with a timeout error.

Top module: `adc_acq_ctrl`

## Requirements
- R1: `req_ready` is high only while the sequencer is idle. A request is taken on a cycle with `req_valid` and `req_ready` both high, and `req_valid` has no effect while a transfer is in progress.
- R2: The command word goes out MSB first on `mosi` with `cs_n` low for the whole operation. Its bits are: bit 7 = 1 (start), bit 6 = unipolar, bit 5 = internal clock, bits 4:3 = operation, bits 2:0 = auxiliary bits. `mosi` changes only while `sclk` is low.
- R3: `sclk` rests low whenever `cs_n` is high. Each high phase lasts DIV system clocks, and each low phase lasts at least DIV.
- R4: External clock, operation 00 (short acquisition): exactly 24 `sclk` pulses are sent. The result is captured MSB first from `miso` on rising edges 9 to 24.
- R5: External clock, operation 11 (long acquisition): exactly 32 pulses are sent, and the result is captured on rising edges 17 to 32.
- R6: Internal clock, operation 00 or 11: after the 8 command pulses, `sclk` stays low until `strobe` is seen high. Then 16 more pulses are sent, capturing on each rising edge, for 24 pulses in all.
- R7: If `strobe` is not seen high within CONV_WAIT_CYC system clocks of an internal conversion, the operation ends with `timeout_err` high and `data` zero.
- R8: Operation 01 (calibration) with internal clock ends when `strobe` is seen high. With external clock, `sclk` keeps running until `strobe` is seen low. Either wait is limited to CAL_WAIT_CYC clocks, after which the operation ends with `timeout_err` high.
- R9: Operation 10 (power-down) sends only the 8 command pulses and ends with `data` zero.
- R10: `done` is a single-cycle pulse. `data` and `data_signed` change only with `done` and hold until the next one. `data_signed` is the inverse of the requested unipolar bit.
- R11: `timeout_err` is updated with each `done` and cleared when the next request is taken.
- R12: While reset is high, `cs_n` is high, `sclk`, `mosi`, `done` and `timeout_err` are low, and `req_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request strobe |
| req_unipolar | input | 1 | 1 = unipolar range, 0 = bipolar range |
| req_internal | input | 1 | 1 = converter uses its own clock |
| req_op | input | 2 | Operation: 00 short conversion, 11 long conversion, 01 calibration, 10 power-down |
| req_port | input | 3 | Auxiliary output bits carried in the command word |
| req_ready | output | 1 | Sequencer idle, request may be taken |
| cs_n | output | 1 | Serial chip select, active low |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data to the converter |
| miso | input | 1 | Serial data from the converter |
| strobe | input | 1 | Converter status strobe, asynchronous |
| done | output | 1 | Single-cycle completion pulse |
| data | output | RES_W | Captured result |
| data_signed | output | 1 | 1 = result is two's complement |
| timeout_err | output | 1 | Last operation hit its wait limit |

## Verification
The bench builds the sequencer with DIV = 3, CONV_WAIT_CYC = 150 and CAL_WAIT_CYC = 1500. The odd divide ratio tests that the high-phase length and the capture points do not rely on a power-of-two ratio. The short wait limits let both timeout paths, including the calibration one, run out within a few thousand cycles. A behavioural converter model in the bench answers in all four operations under both clock sources. It also records the command word and the number of clock pulses per frame, so capture alignment and pulse counts are checked at the pins.

// File: rtl/adcq_pkg.sv
package adcq_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SHIFT,
    ST_WAIT_HI,
    ST_CAL_RUN
  } adcq_state_e;

  typedef enum logic [1:0] {
    OP_SHORT = 2'b00,
    OP_CAL   = 2'b01,
    OP_PDN   = 2'b10,
    OP_LONG  = 2'b11
  } adcq_op_e;

  // what follows the end of a clocked phase
  typedef enum logic [1:0] {
    NX_FINISH,
    NX_WAIT,
    NX_CALRUN
  } adcq_next_e;

  function automatic logic [7:0] adcq_cmd_word(input logic uni, input logic intc,
                                                input logic [1:0] op, input logic [2:0] port);
    return {1'b1, uni, intc, op, port};
  endfunction

endpackage

// File: rtl/adcq_tick.sv
module adcq_tick #(
  parameter int DIV = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic tick
);
  localparam int CW = $clog2(DIV + 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !run) cnt <= '0;
    else if (cnt == CW'(DIV - 1)) cnt <= '0;
    else cnt <= cnt + 1'b1;
  end

  assign tick = run && (cnt == CW'(DIV - 1));
endmodule

// File: rtl/adcq_sync.sv
module adcq_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= '0;
    else chain <= {chain[STAGES-2:0], din};
  end

  assign dout = chain[STAGES-1];
endmodule

// File: rtl/adcq_capture.sv
module adcq_capture #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         shift_en,
  input  logic         din,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst || clr) q <= '0;
    else if (shift_en) q <= {q[W-2:0], din};
  end
endmodule

// File: rtl/adc_acq_ctrl.sv
module adc_acq_ctrl
  import adcq_pkg::*;
#(
  parameter int DIV           = 4,
  parameter int RES_W         = 16,
  parameter int CONV_WAIT_CYC = 1000,
  parameter int CAL_WAIT_CYC  = 400000,
  parameter int SYNC_STAGES   = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  input  logic             req_unipolar,
  input  logic             req_internal,
  input  logic [1:0]       req_op,
  input  logic [2:0]       req_port,
  output logic             req_ready,
  output logic             cs_n,
  output logic             sclk,
  output logic             mosi,
  input  logic             miso,
  input  logic             strobe,
  output logic             done,
  output logic [RES_W-1:0] data,
  output logic             data_signed,
  output logic             timeout_err
);
  localparam int BYTE_W     = 8;
  localparam int ACQ_EXTRA  = 8;
  localparam int SHORT_CLKS = BYTE_W + RES_W;
  localparam int LONG_CLKS  = SHORT_CLKS + ACQ_EXTRA;
  localparam int CNT_W      = $clog2(LONG_CLKS + 1);
  localparam int WAIT_MAX   = (CAL_WAIT_CYC > CONV_WAIT_CYC) ? CAL_WAIT_CYC : CONV_WAIT_CYC;
  localparam int WAIT_W     = $clog2(WAIT_MAX + 1);

  adcq_state_e       state;
  adcq_next_e        nxt;
  logic [BYTE_W-1:0] tx;
  logic [CNT_W-1:0]  edge_cnt, clk_total, cap_lo, rise_num;
  logic [WAIT_W-1:0] wait_cnt, wait_lim;
  logic              cap_on, is_conv, uni_q, cal_seen;
  logic              run, tick, rise_t, fall_t, stb_s, cap_en, acc;
  logic              fin, fin_err;
  logic [RES_W-1:0]  cap_q;

  assign run      = (state == ST_SHIFT) || (state == ST_CAL_RUN);
  assign rise_t   = tick && !sclk;
  assign fall_t   = tick && sclk;
  assign rise_num = edge_cnt + 1'b1;
  assign acc      = req_valid && (state == ST_IDLE);
  assign wait_lim = is_conv ? WAIT_W'(CONV_WAIT_CYC - 1) : WAIT_W'(CAL_WAIT_CYC - 1);
  assign cap_en   = rise_t && (state == ST_SHIFT) && cap_on && (rise_num >= cap_lo) &&
                    ({1'b0, rise_num} < ({1'b0, cap_lo} + (CNT_W + 1)'(RES_W)));
  assign mosi      = tx[BYTE_W-1];
  assign req_ready = (state == ST_IDLE);

  adcq_tick #(.DIV(DIV)) u_tick (.clk(clk), .rst(rst), .run(run), .tick(tick));

  adcq_sync #(.STAGES(SYNC_STAGES)) u_sync (.clk(clk), .rst(rst), .din(strobe), .dout(stb_s));

  adcq_capture #(.W(RES_W)) u_cap (
    .clk(clk), .rst(rst), .clr(acc), .shift_en(cap_en), .din(miso), .q(cap_q)
  );

  always_comb begin
    fin     = 1'b0;
    fin_err = 1'b0;
    case (state)
      ST_SHIFT:   fin = fall_t && (edge_cnt == clk_total) && (nxt == NX_FINISH);
      ST_WAIT_HI: begin
        if (stb_s) fin = !is_conv;
        else if (wait_cnt >= wait_lim) begin
          fin     = 1'b1;
          fin_err = 1'b1;
        end
      end
      ST_CAL_RUN: begin
        if (!sclk && (wait_cnt >= WAIT_W'(CAL_WAIT_CYC - 1))) begin
          fin     = 1'b1;
          fin_err = 1'b1;
        end else fin = fall_t && cal_seen && !stb_s;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= ST_IDLE;
      nxt         <= NX_FINISH;
      tx          <= '0;
      edge_cnt    <= '0;
      clk_total   <= '0;
      cap_lo      <= '0;
      cap_on      <= 1'b0;
      is_conv     <= 1'b0;
      uni_q       <= 1'b0;
      cal_seen    <= 1'b0;
      wait_cnt    <= '0;
      cs_n        <= 1'b1;
      sclk        <= 1'b0;
      done        <= 1'b0;
      data        <= '0;
      data_signed <= 1'b0;
      timeout_err <= 1'b0;
    end else begin
      done <= 1'b0;
      if (fin) begin
        state       <= ST_IDLE;
        cs_n        <= 1'b1;
        sclk        <= 1'b0;
        tx          <= '0;
        done        <= 1'b1;
        data        <= (is_conv && !fin_err) ? cap_q : '0;
        data_signed <= !uni_q;
        timeout_err <= fin_err;
      end else begin
        case (state)
          ST_IDLE: if (acc) begin
            state       <= ST_SHIFT;
            cs_n        <= 1'b0;
            tx          <= adcq_cmd_word(req_unipolar, req_internal, req_op, req_port);
            edge_cnt    <= '0;
            uni_q       <= req_unipolar;
            is_conv     <= (req_op == OP_SHORT) || (req_op == OP_LONG);
            timeout_err <= 1'b0;
            if (!req_internal && (req_op == OP_SHORT || req_op == OP_LONG)) begin
              clk_total <= (req_op == OP_LONG) ? CNT_W'(LONG_CLKS) : CNT_W'(SHORT_CLKS);
              cap_lo    <= (req_op == OP_LONG) ? CNT_W'(BYTE_W + ACQ_EXTRA + 1) : CNT_W'(BYTE_W + 1);
              cap_on    <= 1'b1;
              nxt       <= NX_FINISH;
            end else begin
              clk_total <= CNT_W'(BYTE_W);
              cap_on    <= 1'b0;
              nxt       <= (req_op == OP_PDN) ? NX_FINISH : (req_internal ? NX_WAIT : NX_CALRUN);
            end
          end
          ST_SHIFT: begin
            if (rise_t) begin
              sclk     <= 1'b1;
              edge_cnt <= rise_num;
            end
            if (fall_t) begin
              sclk <= 1'b0;
              tx   <= {tx[BYTE_W-2:0], 1'b0};
              if (edge_cnt == clk_total) begin
                wait_cnt <= '0;
                cal_seen <= 1'b0;
                state    <= (nxt == NX_WAIT) ? ST_WAIT_HI : ST_CAL_RUN;
              end
            end
          end
          ST_WAIT_HI: begin
            wait_cnt <= wait_cnt + 1'b1;
            if (stb_s && is_conv) begin
              state     <= ST_SHIFT;
              edge_cnt  <= '0;
              clk_total <= CNT_W'(RES_W);
              cap_lo    <= CNT_W'(1);
              cap_on    <= 1'b1;
              nxt       <= NX_FINISH;
            end
          end
          ST_CAL_RUN: begin
            wait_cnt <= wait_cnt + 1'b1;
            if (stb_s) cal_seen <= 1'b1;
            if (rise_t) sclk <= 1'b1;
            if (fall_t) sclk <= 1'b0;
          end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/adcq_chk.sv
module adcq_chk #(
  parameter int DIV = 4,
  parameter int RES_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             req_valid,
  input logic             req_ready,
  input logic             cs_n,
  input logic             sclk,
  input logic             mosi,
  input logic             done,
  input logic [RES_W-1:0] data,
  input logic             timeout_err
);
  localparam int HW = $clog2(DIV + 2);
  logic [HW-1:0] hi_cnt;

  always_ff @(posedge clk) begin
    if (rst || !sclk) hi_cnt <= '0;
    else if (hi_cnt != {HW{1'b1}}) hi_cnt <= hi_cnt + 1'b1;
  end

  a_r3_sclk_rests_low: assert property (@(posedge clk) disable iff (rst) cs_n |-> !sclk);
  a_r3_high_phase_len: assert property (@(posedge clk) disable iff (rst)
    $fell(sclk) |-> (hi_cnt == HW'(DIV)));
  a_r2_mosi_steady_high: assert property (@(posedge clk) disable iff (rst)
    (sclk && $past(sclk)) |-> $stable(mosi));
  a_r1_accept_starts_frame: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> (!cs_n && !req_ready));
  a_r10_done_single: assert property (@(posedge clk) disable iff (rst) done |=> !done);
  a_r10_data_hold: assert property (@(posedge clk) disable iff (rst) !done |-> $stable(data));
  a_r11_timeout_with_done: assert property (@(posedge clk) disable iff (rst)
    $rose(timeout_err) |-> done);
endmodule

bind adc_acq_ctrl adcq_chk #(.DIV(DIV), .RES_W(RES_W)) i_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready), .cs_n(cs_n),
  .sclk(sclk), .mosi(mosi), .done(done), .data(data), .timeout_err(timeout_err)
);

// File: tb/test_adc_acq_ctrl.sv
`timescale 1ns/1ps
module test_adc_acq_ctrl;
  localparam int DIV = 3;
  localparam int RES_W = 16;

  logic clk = 1'b0, rst = 1'b1;
  logic req_valid = 1'b0, req_unipolar = 1'b0, req_internal = 1'b0;
  logic [1:0] req_op = 2'b00;
  logic [2:0] req_port = 3'b000;
  logic req_ready, cs_n, sclk, mosi, done, data_signed, timeout_err;
  logic miso = 1'b0, strobe = 1'b1;
  logic [RES_W-1:0] data;

  always #4 clk = ~clk;

  adc_acq_ctrl #(.DIV(DIV), .RES_W(RES_W), .CONV_WAIT_CYC(150), .CAL_WAIT_CYC(1500)) i_adc_acq_ctrl (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_unipolar(req_unipolar),
    .req_internal(req_internal), .req_op(req_op), .req_port(req_port), .req_ready(req_ready),
    .cs_n(cs_n), .sclk(sclk), .mosi(mosi), .miso(miso), .strobe(strobe), .done(done),
    .data(data), .data_signed(data_signed), .timeout_err(timeout_err)
  );

  int n_chk = 0, n_fail = 0, n_done = 0, n_exp = 0;

  task automatic check(input string tag, input string what, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // ---------------- converter model ----------------
  int m_rises = 0, m_falls = 0, m_last_rises = 0, m_rd = 0, m_dly = 0;
  bit m_rd_on = 0;
  logic [7:0] m_ctl = '0;
  logic [15:0] m_res = '0;
  event ev_byte;

  always @(negedge cs_n) begin m_rises = 0; m_falls = 0; m_rd_on = 0; end
  always @(posedge cs_n) begin m_last_rises = m_rises; strobe = 1'b1; miso = 1'b0; m_rd_on = 0; end

  always @(posedge sclk) if (!cs_n) begin
    if (m_rises < 8) m_ctl = {m_ctl[6:0], mosi};
    m_rises++;
    if (m_rises == 8) ->ev_byte;
  end

  always @(negedge sclk) if (!cs_n) begin
    m_falls++;
    if (m_rd_on) begin
      m_rd++;
      miso = (m_rd < 16) ? m_res[15-m_rd] : 1'b0;
    end else if (!m_ctl[5] && (m_ctl[4:3] == 2'b00 || m_ctl[4:3] == 2'b11)) begin
      int st;
      st = (m_ctl[4:3] == 2'b11) ? 16 : 8;
      miso = (m_falls >= st && m_falls < st + 16) ? m_res[15-(m_falls-st)] : 1'b0;
    end
  end

  initial forever begin
    @(ev_byte);
    if (m_ctl[4:3] == 2'b10) begin
    end else if (m_ctl[5]) begin
      strobe = 1'b0;
      if (m_dly >= 0) begin
        repeat (m_dly) @(posedge clk);
        if (m_ctl[4:3] != 2'b01) begin m_rd = 0; m_rd_on = 1; miso = m_res[15]; end
        strobe = 1'b1;
      end
    end else if (m_ctl[4:3] == 2'b01) begin
      strobe = 1'b1;
      repeat (m_dly) @(posedge sclk);
      strobe = 1'b0;
    end
  end

  // ---------------- scoreboard ----------------
  logic [7:0]  q_ctl[$];
  logic [15:0] q_data[$];
  logic        q_sgn[$];
  logic        q_tmo[$];
  int          q_rises[$];
  string       q_tag[$];

  always @(negedge clk) if (!rst && done) begin
    if (q_ctl.size() == 0) check("R1", "unexpected done", 1, 0);
    else begin
      logic [7:0] e_ctl; logic [15:0] e_data; logic e_sgn, e_tmo; int e_r; string t;
      e_ctl = q_ctl.pop_front(); e_data = q_data.pop_front(); e_sgn = q_sgn.pop_front();
      e_tmo = q_tmo.pop_front(); e_r = q_rises.pop_front(); t = q_tag.pop_front();
      check("R2", {t, " command word"}, m_ctl, e_ctl);
      check(t, "data", data, e_data);
      check("R10", {t, " data_signed"}, data_signed, e_sgn);
      check("R11", {t, " timeout_err"}, timeout_err, e_tmo);
      if (e_r >= 0) check(t, "sclk pulses", m_last_rises, e_r);
    end
    n_done++;
  end

  task automatic issue(input bit uni, input bit intc, input logic [1:0] op, input logic [2:0] port,
                       input logic [15:0] res, input int dly, input bit e_tmo, input int rises,
                       input string tag, input bit poke);
    logic [15:0] e_data;
    while (!req_ready) @(negedge clk);
    m_res = res; m_dly = dly;
    e_data = ((op == 2'b00 || op == 2'b11) && !e_tmo) ? res : 16'h0;
    q_ctl.push_back({1'b1, uni, intc, op, port}); q_data.push_back(e_data);
    q_sgn.push_back(!uni); q_tmo.push_back(e_tmo); q_rises.push_back(rises); q_tag.push_back(tag);
    n_exp++;
    req_unipolar = uni; req_internal = intc; req_op = op; req_port = port; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    check("R11", {tag, " timeout_err cleared on accept"}, timeout_err, 0);
    check("R1", {tag, " ready low while busy"}, req_ready, 0);
    if (poke) begin
      repeat (10) @(negedge clk);
      req_valid = 1'b1; req_op = 2'b10; req_port = ~port;
      repeat (2) @(negedge clk);
      req_valid = 1'b0;
    end
    while (n_done < n_exp) @(negedge clk);
    repeat (4) @(negedge clk);
    check("R10", {tag, " data held after done"}, data, e_data);
    check("R3", {tag, " idle: cs_n high"}, cs_n, 1);
    check("R3", {tag, " idle: sclk low"}, sclk, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R12 reset state
    check("R12", "cs_n", cs_n, 1);
    check("R12", "sclk", sclk, 0);
    check("R12", "mosi", mosi, 0);
    check("R12", "done", done, 0);
    check("R12", "req_ready", req_ready, 1);
    check("R12", "timeout_err", timeout_err, 0);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    // R4 external short
    issue(0, 0, 2'b00, 3'b101, 16'h8001, 0, 0, 24, "R4", 0);
    issue(1, 0, 2'b00, 3'b010, 16'h1234, 0, 0, 24, "R4", 0);
    // R5 external long
    issue(1, 0, 2'b11, 3'b111, 16'hFFFF, 0, 0, 32, "R5", 0);
    issue(0, 0, 2'b11, 3'b000, 16'hA5C3, 0, 0, 32, "R5", 0);
    // R6 internal conversions
    issue(0, 1, 2'b00, 3'b001, 16'h7FFE, 60, 0, 24, "R6", 0);
    issue(1, 1, 2'b11, 3'b110, 16'h5555, 10, 0, 24, "R6", 0);
    // R7 internal conversion timeout
    issue(0, 1, 2'b00, 3'b011, 16'hBEEF, -1, 1, 8, "R7", 0);
    // R11 flag cleared by next operation
    issue(1, 0, 2'b00, 3'b100, 16'h0F0F, 0, 0, 24, "R11", 0);
    // R8 calibration, internal then external, then internal timeout
    issue(0, 1, 2'b01, 3'b010, 16'h0000, 400, 0, 8, "R8", 0);
    issue(0, 0, 2'b01, 3'b001, 16'h0000, 40, 0, -1, "R8", 0);
    issue(1, 1, 2'b01, 3'b111, 16'h0000, -1, 1, 8, "R8", 0);
    // R9 power-down
    issue(0, 0, 2'b10, 3'b011, 16'hFFFF, 0, 0, 8, "R9", 0);
    // R1 request while busy is ignored
    issue(0, 0, 2'b00, 3'b110, 16'h3C3C, 0, 0, 24, "R1", 1);
    repeat (30) @(negedge clk);
    check("R1", "done count", n_done, n_exp);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule